// File: doc/BRIEF.md
# Time-Division Channel Sequencer with Blanking Window

This block steers an external analog demultiplexer switch. A recovered slot clock marks the start of each time slot, and an in-band framing marker recurs once per frame. Both inputs are synchronous to a fast timing clock. From them the block produces a channel address that steps once per slot, and a switch enable that closes the switch only inside a narrowed window in each slot. The window opens a programmable number of timing cycles after the slot edge and stays open for a programmable number of cycles. This keeps sampling clear of the switching spikes at slot boundaries and of any fixed clock phase error.

A frame holds `NUM_CH` signal slots, addressed 0 to `NUM_CH-1`, followed by one framing slot at address `NUM_CH`. The switch is never enabled in the framing slot. When a marker is seen, the address goes back to 0 at the next slot edge, which keeps channel numbering aligned. A marker that shows up outside the framing slot also raises a one-cycle resync error.

Top module: `tdm_slot_sequencer`

## Requirements
- R1: While reset is held and directly after it, the address equals `NUM_CH` (10 by default, the framing slot), the frame-slot flag is 1, and the switch enable and resync error are 0.
- R2: The address changes only at a slot edge, which is a rising edge of `slot_clk_i`. At each edge it steps from k to k+1 and wraps from `NUM_CH` to 0, so a frame runs 0,1,...,`NUM_CH`.
- R3: The frame-slot flag is 1 exactly while the address equals `NUM_CH`. The switch enable is never 1 while the flag is 1.
- R4: Phase 0 is the first timing cycle after a slot edge. The window opens at phase `win_delay_i`, and a delay of 0 is treated as 1.
- R5: The window stays open for `win_width_i` consecutive timing cycles.
- R6: Delay and width act independently: changing one does not change the effect of the other.
- R7: Once a slot length of P cycles has been measured, the enable is 0 in the last cycle of a slot (phase P-1). A window that would reach that cycle is cut off at phase P-2.
- R8: A marker that rises during the framing slot raises no error, and the next slot has address 0.
- R9: A marker that rises in any other slot raises `resync_err_o` for exactly one cycle, in the cycle after the marker is first sampled high. The next slot has address 0.
- R10: A width of 0 keeps the enable at 0 for the whole slot.
- R11: The address never changes in a cycle that follows a cycle with the enable at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast timing clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| slot_clk_i | input | 1 | Recovered slot clock; a rising edge starts a slot |
| frame_mark_i | input | 1 | Framing marker; its rising edge counts |
| win_delay_i | input | 8 | Window delay in timing cycles from the slot edge |
| win_width_i | input | 8 | Window width in timing cycles |
| chan_addr_o | output | $clog2(NUM_CH+1) | Channel address for the switch |
| sw_en_o | output | 1 | Switch enable |
| frame_slot_o | output | 1 | High during the framing slot |
| resync_err_o | output | 1 | One-cycle pulse for a misplaced marker |

## Verification
Every result is registered. A slot edge driven before clock edge t first shows on the address, the flag and the enable at t, and the bench calls that sample phase 0. Each later sample, taken on the falling clock edge, is one phase further on. The window is therefore expected at phases max(delay,1) through max(delay,1)+width-1, limited to P-2 once a slot length has been measured. A marker raised just after the phase-k sample produces its error pulse at phase k+1, and the address returns to 0 at the next slot's phase 0. The bench compares every phase of every slot with this schedule.

// File: rtl/tdm_seq_pkg.sv
package tdm_seq_pkg;
    localparam int SET_W = 8;
    typedef logic [SET_W-1:0] setting_t;
endpackage

// File: rtl/tdm_edge_detect.sv
module tdm_edge_detect #(
    parameter int N = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] sig_i,
    output logic [N-1:0] rise_o
);
    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = sig_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= '0;
        else         prev_q <= prev_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_rise
        assign rise_o[i] = sig_i[i] & ~prev_q[i];
    end
endmodule

// File: rtl/tdm_chan_counter.sv
module tdm_chan_counter #(
    parameter int NUM_CH = 10,
    parameter int AW     = $clog2(NUM_CH + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          slot_edge_i,
    input  logic          mark_edge_i,
    output logic [AW-1:0] addr_o,
    output logic          frame_o,
    output logic          frame_next_o,
    output logic          err_o
);
    localparam logic [AW-1:0] FRAME = AW'(NUM_CH);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic          frame;
        logic          pend;
        logic          err;
    } cnt_t;

    cnt_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.err = mark_edge_i && (s_q.addr != FRAME);
        if (slot_edge_i) begin
            if (mark_edge_i || s_q.pend || s_q.addr == FRAME) s_d.addr = '0;
            else                                              s_d.addr = s_q.addr + 1'b1;
            s_d.pend = 1'b0;
        end else if (mark_edge_i) begin
            s_d.pend = 1'b1;
        end
        s_d.frame = (s_d.addr == FRAME);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '{addr: FRAME, frame: 1'b1, pend: 1'b0, err: 1'b0};
        else         s_q <= s_d;
    end

    assign addr_o       = s_q.addr;
    assign frame_o      = s_q.frame;
    assign frame_next_o = s_d.frame;
    assign err_o        = s_q.err;

    // R2
    addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !slot_edge_i |=> $stable(s_q.addr));
    // R2
    addr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.addr <= FRAME);
    // R9
    err_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.err |=> !s_q.err);
endmodule

// File: rtl/tdm_blank_window.sv
module tdm_blank_window
    import tdm_seq_pkg::*;
#(
    parameter int PH_W = 10
) (
    input  logic     clk_i,
    input  logic     rst_ni,
    input  logic     slot_edge_i,
    input  logic     frame_next_i,
    input  setting_t delay_i,
    input  setting_t width_i,
    output logic     en_o
);
    localparam int CW = PH_W + 1;
    localparam logic [PH_W-1:0] PH_MAX = {PH_W{1'b1}};

    typedef struct packed {
        logic [PH_W-1:0] phase;
        logic [PH_W-1:0] period;
        logic            en;
    } win_t;

    win_t s_d, s_q;
    logic          sat;
    logic [CW-1:0] start_w, stop_w, ph_w, per_w;
    logic          in_win, fits;

    always_comb begin
        s_d = s_q;
        sat = (s_q.phase == PH_MAX);
        if (slot_edge_i) begin
            s_d.phase  = '0;
            s_d.period = sat ? PH_MAX : s_q.phase + 1'b1;
        end else begin
            s_d.phase  = sat ? PH_MAX : s_q.phase + 1'b1;
        end
        start_w = (delay_i == '0) ? CW'(1) : CW'(delay_i);
        stop_w  = start_w + CW'(width_i);
        ph_w    = CW'(s_d.phase);
        per_w   = CW'(s_d.period);
        in_win  = (ph_w >= start_w) && (ph_w < stop_w);
        fits    = (ph_w + CW'(1)) < per_w;
        s_d.en  = in_win && fits && !frame_next_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '{phase: PH_MAX, period: PH_MAX, en: 1'b0};
        else         s_q <= s_d;
    end

    assign en_o = s_q.en;

    // R4
    win_late_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.en |-> (s_q.phase != '0));
    // R7
    win_trunc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (slot_edge_i && s_q.period != PH_MAX && (s_q.phase + 1'b1) == s_q.period) |-> !s_q.en);
endmodule

// File: rtl/tdm_slot_sequencer.sv
module tdm_slot_sequencer
    import tdm_seq_pkg::*;
#(
    parameter int NUM_CH = 10,
    parameter int PH_W   = 10,
    parameter int AW     = $clog2(NUM_CH + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          slot_clk_i,
    input  logic          frame_mark_i,
    input  logic [7:0]    win_delay_i,
    input  logic [7:0]    win_width_i,
    output logic [AW-1:0] chan_addr_o,
    output logic          sw_en_o,
    output logic          frame_slot_o,
    output logic          resync_err_o
);
    logic [1:0] rise;
    logic       frame_next;

    tdm_edge_detect #(.N(2)) edge_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .sig_i  ({frame_mark_i, slot_clk_i}),
        .rise_o (rise)
    );

    tdm_chan_counter #(.NUM_CH(NUM_CH), .AW(AW)) cnt_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .slot_edge_i  (rise[0]),
        .mark_edge_i  (rise[1]),
        .addr_o       (chan_addr_o),
        .frame_o      (frame_slot_o),
        .frame_next_o (frame_next),
        .err_o        (resync_err_o)
    );

    tdm_blank_window #(.PH_W(PH_W)) win_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .slot_edge_i  (rise[0]),
        .frame_next_i (frame_next),
        .delay_i      (setting_t'(win_delay_i)),
        .width_i      (setting_t'(win_width_i)),
        .en_o         (sw_en_o)
    );

    // R11
    addr_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (chan_addr_o != $past(chan_addr_o)) |-> !$past(sw_en_o));
    // R3
    frame_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_slot_o |-> !sw_en_o);
endmodule

// File: tb/tdm_slot_sequencer_tb.sv
module tdm_slot_sequencer_tb_top;
    localparam int CLK_PERIOD = 20;
    localparam int P          = 20;
    localparam int NCH        = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slot_clk = 1'b0;
    logic       mark = 1'b0;
    logic [7:0] dly = 8'd3;
    logic [7:0] wid = 8'd5;
    logic [3:0] addr;
    logic       en, frm, err;

    int checks = 0;
    int errors = 0;
    int exp_addr = NCH;
    bit period_known = 1'b0;
    int edges = 0;
    logic en_s [P];
    logic err_s [P];
    int   addr_s;
    logic frame_s;

    always #(CLK_PERIOD/2) clk = ~clk;

    tdm_slot_sequencer dut_i (
        .clk_i(clk), .rst_ni(rst_n), .slot_clk_i(slot_clk), .frame_mark_i(mark),
        .win_delay_i(dly), .win_width_i(wid), .chan_addr_o(addr), .sw_en_o(en),
        .frame_slot_o(frm), .resync_err_o(err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic run_slot(input bit mk, input int mk_k);
        slot_clk = 1'b1;
        for (int k = 0; k < P; k++) begin
            @(negedge clk);
            en_s[k]  = en;
            err_s[k] = err;
            if (k == 0) begin
                addr_s  = int'(addr);
                frame_s = frm;
            end
            mark = mk && (k == mk_k);
            if (k == P/2 - 1) slot_clk = 1'b0;
        end
        mark = 1'b0;
        edges++;
        if (edges >= 2) period_known = 1'b1;
    endtask

    // Runs one slot and checks address, flag, window and error against the requirements.
    task automatic slot_check(input int d, input int w, input bit mk, input int mk_k, input string tag);
        int start, stop, bad, ebad, cnt;
        bit known;
        dly = 8'(d);
        wid = 8'(w);
        exp_addr = (exp_addr == NCH) ? 0 : exp_addr + 1;
        known = period_known;
        run_slot(mk, mk_k);
        chk(addr_s == exp_addr, "R2 address sequence", addr_s, exp_addr);
        chk(frame_s == (exp_addr == NCH), "R3 frame-slot flag", int'(frame_s), int'(exp_addr == NCH));
        start = (d == 0) ? 1 : d;
        stop  = start + w;
        bad = 0; cnt = 0;
        for (int k = 0; k < P; k++) begin
            bit e;
            e = (exp_addr != NCH) && (k >= start) && (k < stop) && (!known || k < P - 1);
            if (en_s[k] !== e) bad++;
            if (en_s[k] === 1'b1) cnt++;
        end
        chk(bad == 0, tag, cnt, (exp_addr == NCH) ? 0 : w);
        ebad = 0;
        for (int k = 0; k < P; k++) begin
            bit e;
            e = mk && (exp_addr != NCH) && (k == mk_k + 1);
            if (err_s[k] !== e) ebad++;
        end
        chk(ebad == 0, mk ? "R8 R9 resync error timing" : "R9 no spurious error", ebad, 0);
        if (mk) exp_addr = NCH;
    endtask

    task automatic t_reset();
        chk(addr == 4'(NCH), "R1 reset address", int'(addr), NCH);
        chk(frm == 1'b1, "R1 reset frame flag", int'(frm), 1);
        chk(en == 1'b0, "R1 reset enable", int'(en), 0);
        chk(err == 1'b0, "R1 reset error", int'(err), 0);
    endtask

    task automatic t_sequence();
        for (int i = 0; i < 2 * (NCH + 1); i++)
            slot_check(3, 5, 1'b0, 0, "R4 R5 R11 window d3 w5");
    endtask

    task automatic t_independent();
        slot_check(6, 5, 1'b0, 0, "R6 delay change keeps width");
        slot_check(6, 2, 1'b0, 0, "R6 width change keeps delay");
        slot_check(0, 4, 1'b0, 0, "R4 zero delay opens at phase 1");
        slot_check(1, 1, 1'b0, 0, "R5 single-cycle window");
    endtask

    task automatic t_trunc();
        slot_check(10, 20, 1'b0, 0, "R7 R11 truncated window");
        slot_check(17, 8, 1'b0, 0, "R7 truncated late window");
    endtask

    task automatic t_width0();
        slot_check(4, 0, 1'b0, 0, "R10 zero width");
    endtask

    task automatic t_mark_aligned();
        while (exp_addr != NCH - 1) slot_check(3, 5, 1'b0, 0, "R2 advance to frame");
        slot_check(3, 5, 1'b1, 5, "R8 marker in framing slot");
        slot_check(3, 5, 1'b0, 0, "R8 slot after aligned marker");
    endtask

    task automatic t_mark_mis();
        while (exp_addr != 3) slot_check(3, 5, 1'b0, 0, "R2 advance to slot 4");
        slot_check(3, 5, 1'b1, 5, "R9 misplaced marker slot");
        slot_check(3, 5, 1'b0, 0, "R9 slot after misplaced marker");
        slot_check(3, 5, 1'b0, 0, "R9 count resumes");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_sequence();
        t_independent();
        t_trunc();
        t_width0();
        t_mark_aligned();
        t_mark_mis();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule